// File: doc/BRIEF.md
# Addressable Serial Character Receiver

This block receives asynchronous serial characters from a line that several receivers share. A character starts with a low start bit. Eight data bits follow, least significant first. In nine-bit mode a ninth bit comes next. A single stop bit closes the character. The line is oversampled by a tick that runs at sixteen times the bit rate. Each bit is decided by a majority vote over three samples taken around the middle of the bit.

The block has an addressing filter that the host can switch on and off. While the filter is on, the receiver keeps only address characters and discards data characters without touching any status. In nine-bit mode the ninth bit tells the two kinds apart. In eight-bit mode the stop bit does: a high stop bit marks an address, and a low stop bit marks data. Software reads the address. If the address is its own, software switches the filter off and takes the data characters that follow. Comparing the address is the job of software. The block itself has no transmitter and no baud generator. Host writes to the shared data location go to a separate transmit holding register.

Top module: `mpc_uart_rx`

## Requirements
- R1: After reset, rxDone, frameErr, overrun, mpMode, rxBit9 and rxData are all zero, and the receiver waits idle for a high-to-low edge on rxLine.
- R2: Each bit lasts 16 baudTick pulses. Data bits arrive least significant first, and each bit is the majority of the samples at ticks 7, 8 and 9 of its period, so a line disturbance lasting one tick inside that window does not change the bit.
- R3: A start edge is rejected, and nothing is received, if the vote at the middle of the start bit is high.
- R4: With nineBitMode low, a character whose stop bit is 1 is an address character and one whose stop bit is 0 is a data character. Every accepted character with a stop bit of 0 sets frameErr. rxBit9 reads 0 in this mode.
- R5: With nineBitMode high, a ninth bit of 1 marks an address character and 0 marks a data character. The ninth bit of an accepted character appears on rxBit9. A stop bit of 0 sets frameErr.
- R6: With mpMode at 1, an address character is received normally: rxData takes the byte and rxDone is set.
- R7: With mpMode at 1, a data character is discarded. rxData, rxBit9, rxDone, frameErr and overrun all keep their values.
- R8: With mpMode at 0, every character is received normally, whatever its kind.
- R9: A one-cycle hostRd pulse clears rxDone, frameErr and overrun. These flags otherwise change only when a character is accepted.
- R10: A character that is accepted while rxDone is still set is dropped. overrun is set, and rxData keeps the earlier byte. A discarded data character never sets overrun.
- R11: A hostWr pulse loads hostWrData into txHold and leaves rxData unchanged.
- R12: A modeWr pulse loads modeVal into the filter bit, which is visible on mpMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input line, idle high |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| nineBitMode | input | 1 | 1 selects nine-bit characters |
| modeWr | input | 1 | Write strobe for the addressing filter bit |
| modeVal | input | 1 | Value loaded into the filter bit by modeWr |
| hostRd | input | 1 | Host read of the received byte; clears the flags |
| hostWr | input | 1 | Host write to the shared data location |
| hostWrData | input | 8 | Write data for the transmit holding register |
| rxData | output | 8 | Last accepted byte |
| rxBit9 | output | 1 | Ninth bit of the last accepted character |
| rxDone | output | 1 | Receive-complete flag |
| frameErr | output | 1 | Stop bit of the last accepted character was 0 |
| overrun | output | 1 | An accepted character was lost because rxDone was set |
| mpMode | output | 1 | Addressing filter bit |
| txHold | output | 8 | Transmit holding register |

## Verification
The assertions assume three things about the inputs. nineBitMode does not change while a character is on the line. hostRd, hostWr and modeWr are single-cycle pulses. baudTick never comes on two cycles in a row. The bench changes mode and nineBitMode only while the line is idle between characters. It issues host strobes as one-cycle pulses on the falling clock edge, and it makes baudTick from a divide-by-four counter. The check that a data character leaves the status alone is written for the eight-bit case, where the stop-bit vote is visible between the control and the datapath. The nine-bit case is covered by directed stimulus.

// File: rtl/mpc_uart_pkg.sv
package mpc_uart_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rxState_e;

  // Strobes from the control FSM to the datapath, at most one per cycle
  typedef struct packed {
    logic sampA;     // first of the three middle samples
    logic sampB;     // second middle sample
    logic shiftIn;   // vote decided for a data bit
    logic takeNinth; // vote decided for the ninth bit
    logic finish;    // vote decided for the stop bit, character ends
  } rxStrobe_t;

endpackage

// File: rtl/mpc_uart_rx_ctrl.sv
module mpc_uart_rx_ctrl
  import mpc_uart_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baudTick,
  input  logic       nineBitMode,
  input  logic       fallEdge,
  input  logic       voteBit,
  output rxStrobe_t  strb
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [CW-1:0] SMP_A    = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] SMP_B    = CW'(OVS / 2);
  localparam logic [CW-1:0] SMP_C    = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

  rxState_e        state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitIdx;

  always_comb begin
    strb = '0;
    if (baudTick && state != RX_IDLE) begin
      strb.sampA = (cnt == SMP_A);
      strb.sampB = (cnt == SMP_B);
      if (cnt == SMP_C) begin
        strb.shiftIn   = (state == RX_DATA);
        strb.takeNinth = (state == RX_NINTH);
        strb.finish    = (state == RX_STOP);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (state == RX_IDLE) begin
      cnt    <= '0;
      bitIdx <= '0;
      if (fallEdge) state <= RX_START;
    end else if (baudTick) begin
      if (cnt == SMP_C && ((state == RX_START && voteBit) || state == RX_STOP)) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        case (state)
          RX_START: state <= RX_DATA;
          RX_DATA: begin
            if (bitIdx == BIT_LAST) state <= nineBitMode ? RX_NINTH : RX_STOP;
            else                    bitIdx <= bitIdx + 1'b1;
          end
          RX_NINTH: state <= RX_STOP;
          default:  state <= RX_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mpc_uart_rx_dp.sv
module mpc_uart_rx_dp
  import mpc_uart_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxLine,
  input  rxStrobe_t            strb,
  input  logic                 nineBitMode,
  input  logic                 hostRd,
  input  logic                 hostWr,
  input  logic [DATA_BITS-1:0] hostWrData,
  input  logic                 modeWr,
  input  logic                 modeVal,
  output logic                 fallEdge,
  output logic                 voteBit,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxDone,
  output logic                 frameErr,
  output logic                 overrun,
  output logic                 mpMode,
  output logic [DATA_BITS-1:0] txHold
);

  logic [1:0]           syncQ;
  logic                 linePrev;
  logic                 lineS;
  logic                 smpA, smpB;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 ninthReg;
  logic                 isAddr, accept, busy;

  assign lineS    = syncQ[1];
  assign fallEdge = linePrev & ~lineS;
  assign voteBit  = (smpA & smpB) | (smpA & lineS) | (smpB & lineS);

  // At the stop-bit decision voteBit is the stop bit itself
  assign isAddr = nineBitMode ? ninthReg : voteBit;
  assign accept = strb.finish && (!mpMode || isAddr);
  assign busy   = rxDone && !hostRd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ    <= 2'b11;
      linePrev <= 1'b1;
      smpA     <= 1'b1;
      smpB     <= 1'b1;
      shiftReg <= '0;
      ninthReg <= 1'b0;
    end else begin
      syncQ    <= {syncQ[0], rxLine};
      linePrev <= lineS;
      if (strb.sampA)     smpA <= lineS;
      if (strb.sampB)     smpB <= lineS;
      if (strb.shiftIn)   shiftReg <= {voteBit, shiftReg[DATA_BITS-1:1]};
      if (strb.takeNinth) ninthReg <= voteBit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxDone   <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else if (accept && !busy) begin
      rxData   <= shiftReg;
      rxBit9   <= nineBitMode & ninthReg;
      rxDone   <= 1'b1;
      frameErr <= ~voteBit;
      overrun  <= 1'b0;
    end else if (accept) begin
      overrun  <= 1'b1;
    end else if (hostRd) begin
      rxDone   <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpMode <= 1'b0;
      txHold <= '0;
    end else begin
      if (modeWr) mpMode <= modeVal;
      if (hostWr) txHold <= hostWrData;
    end
  end

endmodule

// File: rtl/mpc_uart_rx.sv
module mpc_uart_rx
  import mpc_uart_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxLine,
  input  logic                 baudTick,
  input  logic                 nineBitMode,
  input  logic                 modeWr,
  input  logic                 modeVal,
  input  logic                 hostRd,
  input  logic                 hostWr,
  input  logic [DATA_BITS-1:0] hostWrData,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxDone,
  output logic                 frameErr,
  output logic                 overrun,
  output logic                 mpMode,
  output logic [DATA_BITS-1:0] txHold
);

  rxStrobe_t strb;
  logic      fallEdge;
  logic      voteBit;

  mpc_uart_rx_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .baudTick    (baudTick),
    .nineBitMode (nineBitMode),
    .fallEdge    (fallEdge),
    .voteBit     (voteBit),
    .strb        (strb)
  );

  mpc_uart_rx_dp #(.DATA_BITS(DATA_BITS)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxLine      (rxLine),
    .strb        (strb),
    .nineBitMode (nineBitMode),
    .hostRd      (hostRd),
    .hostWr      (hostWr),
    .hostWrData  (hostWrData),
    .modeWr      (modeWr),
    .modeVal     (modeVal),
    .fallEdge    (fallEdge),
    .voteBit     (voteBit),
    .rxData      (rxData),
    .rxBit9      (rxBit9),
    .rxDone      (rxDone),
    .frameErr    (frameErr),
    .overrun     (overrun),
    .mpMode      (mpMode),
    .txHold      (txHold)
  );

endmodule

// File: rtl/mpc_uart_rx_chk.sv
module mpc_uart_rx_chk
  import mpc_uart_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input rxStrobe_t            strb,
  input logic                 voteBit,
  input logic                 nineBitMode,
  input logic                 hostRd,
  input logic                 hostWr,
  input logic                 mpMode,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxBit9,
  input logic                 rxDone,
  input logic                 frameErr,
  input logic                 overrun
);

  // R2: the control never issues two strobes in one cycle
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.sampA, strb.sampB, strb.shiftIn, strb.takeNinth, strb.finish}));

  // R7: an eight-bit data character under the filter leaves all status alone
  p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish && mpMode && !nineBitMode && !voteBit && !hostRd
    |=> $stable(rxData) && $stable(rxBit9) && $stable(rxDone)
        && $stable(frameErr) && $stable(overrun));

  // R9: a host read clears every flag
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hostRd && !strb.finish |=> !rxDone && !frameErr && !overrun);

  // R6: receive-complete rises only when a character ends
  p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxDone) |-> $past(strb.finish));

  // R10: overrun rises only on a character ending while the flag is still set
  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rxDone) && $past(strb.finish));

  // R10: the byte that is held is kept while the flag is set
  p_overrun_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish && rxDone && !hostRd |=> $stable(rxData));

  // R11: a host write never reaches the receive register
  p_write_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hostWr && !strb.finish |=> $stable(rxData));

  // R4: a framing error is reported only together with a received character
  p_fe_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |-> rxDone);

endmodule

bind mpc_uart_rx mpc_uart_rx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .strb        (strb),
  .voteBit     (voteBit),
  .nineBitMode (nineBitMode),
  .hostRd      (hostRd),
  .hostWr      (hostWr),
  .mpMode      (mpMode),
  .rxData      (rxData),
  .rxBit9      (rxBit9),
  .rxDone      (rxDone),
  .frameErr    (frameErr),
  .overrun     (overrun)
);

// File: tb/mpc_uart_rx_tb_top.sv
module mpc_uart_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  typedef struct packed {
    logic       nine;
    logic       mode;
    logic [7:0] data;
    logic       b9;
    logic       stop;
    logic       expAcc;
    logic       expFe;
  } vec_t;

  // nine, mode, data, ninth, stop, accepted, frame error
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h81, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 8'h22, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 8'h33, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 8'h44, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 8'h55, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxLine = 1'b1;
  logic       baudTick;
  logic       nineBitMode = 1'b0;
  logic       modeWr = 1'b0, modeVal = 1'b0;
  logic       hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] rxData, txHold;
  logic       rxBit9, rxDone, frameErr, overrun, mpMode;

  int   nTests = 0;
  int   nFail  = 0;
  logic [7:0] shData = '0;
  logic       sh9 = 1'b0;
  logic [1:0] divCnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) divCnt <= '0;
    else        divCnt <= divCnt + 1'b1;
  assign baudTick = (divCnt == 2'd3);

  mpc_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .baudTick(baudTick),
    .nineBitMode(nineBitMode), .modeWr(modeWr), .modeVal(modeVal),
    .hostRd(hostRd), .hostWr(hostWr), .hostWrData(hostWrData),
    .rxData(rxData), .rxBit9(rxBit9), .rxDone(rxDone), .frameErr(frameErr),
    .overrun(overrun), .mpMode(mpMode), .txHold(txHold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_read();
    @(negedge clk); hostRd = 1'b1;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk); modeWr = 1'b1; modeVal = v;
    @(negedge clk); modeWr = 1'b0;
  endtask

  task automatic hold_line(input logic v, input int clks);
    rxLine = v;
    repeat (clks) @(negedge clk);
  endtask

  // glitchIdx selects a data bit that gets a one-tick inversion at its middle
  task automatic send_char(input logic nine, input logic [7:0] d, input logic b9,
                           input logic stp, input int glitchIdx);
    @(negedge clk);
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      if (i == glitchIdx) begin
        hold_line(d[i], BIT_CLKS / 2);
        hold_line(~d[i], TICK_DIV);
        hold_line(d[i], BIT_CLKS / 2 - TICK_DIV);
      end else begin
        hold_line(d[i], BIT_CLKS);
      end
    end
    if (nine) hold_line(b9, BIT_CLKS);
    hold_line(stp, BIT_CLKS);
    hold_line(1'b1, 8);
  endtask

  function automatic string tag_of(input vec_t v);
    string a, b;
    a = v.nine ? "R5" : "R4";
    b = v.mode ? (v.expAcc ? "R6" : "R7") : "R8";
    return {a, " ", b};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 rxDone", rxDone, 0);
    chk("R1 flags", {frameErr, overrun, mpMode, rxBit9}, 0);
    chk("R1 rxData", rxData, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 idle after reset", rxDone, 0);

    // table of characters
    for (int k = 0; k < 9; k++) begin
      host_read();
      set_mode(VECS[k].mode);
      nineBitMode = VECS[k].nine;
      send_char(VECS[k].nine, VECS[k].data, VECS[k].b9, VECS[k].stop, -1);
      if (VECS[k].expAcc) begin
        shData = VECS[k].data;
        sh9    = VECS[k].nine & VECS[k].b9;
      end
      chk({tag_of(VECS[k]), " done"}, rxDone, VECS[k].expAcc);
      chk({tag_of(VECS[k]), " data"}, rxData, shData);
      chk({tag_of(VECS[k]), " ninth"}, rxBit9, sh9);
      chk({tag_of(VECS[k]), " frame"}, frameErr, VECS[k].expFe);
      chk({tag_of(VECS[k]), " overrun"}, overrun, 0);
    end

    // R12: filter bit follows writes
    set_mode(1'b1);
    chk("R12 mode set", mpMode, 1);
    set_mode(1'b0);
    chk("R12 mode clear", mpMode, 0);
    nineBitMode = 1'b0;

    // R9: read clears flags (frame error still set from last vector)
    host_read();
    chk("R9 cleared", {rxDone, frameErr, overrun}, 0);

    // R10: overrun keeps the first byte
    send_char(1'b0, 8'h12, 1'b0, 1'b1, -1);
    send_char(1'b0, 8'h34, 1'b0, 1'b1, -1);
    chk("R10 overrun set", overrun, 1);
    chk("R10 data kept", rxData, 8'h12);
    chk("R10 done held", rxDone, 1);
    host_read();
    chk("R9 overrun cleared", {rxDone, frameErr, overrun}, 0);

    // R10/R7: discarded data character causes no overrun
    send_char(1'b0, 8'h56, 1'b0, 1'b1, -1);
    set_mode(1'b1);
    send_char(1'b0, 8'h78, 1'b0, 1'b0, -1);
    chk("R10 no overrun on drop", overrun, 0);
    chk("R7 data unchanged", rxData, 8'h56);
    chk("R7 frame unchanged", frameErr, 0);

    // R11: host write goes elsewhere
    @(negedge clk); hostWr = 1'b1; hostWrData = 8'hEE;
    @(negedge clk); hostWr = 1'b0;
    chk("R11 tx hold", txHold, 8'hEE);
    chk("R11 rx untouched", rxData, 8'h56);
    chk("R11 done untouched", rxDone, 1);
    set_mode(1'b0);
    host_read();

    // R3: short start pulse is rejected
    hold_line(1'b0, 3 * TICK_DIV);
    hold_line(1'b1, BIT_CLKS * 2);
    chk("R3 false start", rxDone, 0);
    send_char(1'b0, 8'hC3, 1'b0, 1'b1, -1);
    chk("R3 recovers", rxData, 8'hC3);
    host_read();

    // R2: one-tick disturbance inside the voting window
    send_char(1'b0, 8'h96, 1'b0, 1'b1, 3);
    chk("R2 majority vote", rxData, 8'h96);
    chk("R2 done", rxDone, 1);
    host_read();
    send_char(1'b0, 8'h01, 1'b0, 1'b1, 0);
    chk("R2 lsb first", rxData, 8'h01);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule